// File: doc/BRIEF.md
# USB Device SETUP Stage Receiver

This block is the device-side receive engine for the SETUP stage of a USB control transfer. It takes token packets that have already been decoded (PID, device address, endpoint number), then the PID of the following data packet and its payload bytes one at a time. A fixed chain of checks decides whether the transaction is accepted. The token must be a SETUP token. It must carry the programmed device address. The endpoint must be enabled and configured for control. The data PID must be a clean DATA0. The endpoint's setup-received flag must be clear. If any check fails, the packet is dropped and the engine returns to idle to wait for the next token.

An accepted transaction fetches the endpoint's buffer base address from a small descriptor table. The payload bytes are written through a byte-wide memory write port, starting at that base address, and writing stops at the endpoint's maximum payload size. When upstream logic signals a good end of packet, the engine sets the endpoint's setup-received flag and stores the number of bytes written in the descriptor. The endpoint's bank-ready state plays no part in the decision. Handshake generation, the serial engine and CRC checking are outside this block; upstream logic supplies the good/bad packet indication.

Top module: `usbsetup_rx`

## Requirements
- R1: A token whose address differs from `dev_addr` is dropped: the data that follows causes no memory write and sets no flag.
- R2: A SETUP token to an endpoint whose bit in `ep_enabled` is 0 is dropped, with no write and no flag set.
- R3: A SETUP token to an endpoint whose bit in `ep_ctrl` is 0 (not control type) is dropped, with no write and no flag set.
- R4: Only token PID 4'b1101 (SETUP) starts a transaction. Any other token PID, such as OUT 4'b0001, is dropped.
- R5: In the data phase, a PID error (`dpid_err`=1) or any PID other than DATA0 (4'b0011) returns the engine to idle, with no write.
- R6: After DATA0, while the endpoint's flag is clear, the k-th payload byte (k from 0) is written at base+k. `mem_we` is asserted in the same cycle as `byte_valid`.
- R7: Bytes past the endpoint's maximum payload size (field e of `ep_max_flat`, bits [7e+6:7e]) are not written. The stored count is the smaller of the bytes received and that maximum.
- R8: If the endpoint's setup flag is already set, the payload is dropped: no write, and the stored count is unchanged.
- R9: A good end of packet (`eop_valid`=1, `eop_good`=1) sets the endpoint's flag and stores the count one cycle later. A bad end of packet sets no flag and keeps the old count.
- R10: A token that arrives while the engine is waiting for data or receiving aborts the transaction, and the new token is checked from the start.
- R11: `flag_clr[e]` clears flag e. When a set and a clear hit the same endpoint in the same cycle, the set wins.
- R12: After reset, all flags, counts and buffer bases are 0 and `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_addr | input | 7 | Programmed device address |
| ep_enabled | input | NEP | Per-endpoint enable |
| ep_ctrl | input | NEP | Per-endpoint control-type marker |
| ep_max_flat | input | NEP*CW | Packed per-endpoint maximum payload sizes |
| tok_valid | input | 1 | Decoded token present |
| tok_pid | input | 4 | Token PID |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | EPW | Token endpoint number |
| dpid_valid | input | 1 | Data packet PID present |
| dpid | input | 4 | Data packet PID |
| dpid_err | input | 1 | PID check failure on the data packet |
| byte_valid | input | 1 | Payload byte present |
| byte_data | input | 8 | Payload byte |
| eop_valid | input | 1 | End of data packet |
| eop_good | input | 1 | Packet passed upstream checks |
| desc_wr_en | input | 1 | Load a buffer base into the descriptor table |
| desc_wr_ep | input | EPW | Endpoint of the base load |
| desc_wr_addr | input | AW | Buffer base value |
| desc_rd_ep | input | EPW | Endpoint selected for readout |
| desc_rd_addr | output | AW | Buffer base of the selected endpoint |
| desc_rd_cnt | output | CW | Stored byte count of the selected endpoint |
| mem_we | output | 1 | Buffer byte write strobe |
| mem_addr | output | AW | Buffer byte address |
| mem_wdata | output | 8 | Buffer byte data |
| flag_clr | input | NEP | Per-endpoint setup flag clear |
| setup_flag | output | NEP | Per-endpoint setup-received flags |

## Verification
Two things can happen on one endpoint in the same cycle: the engine setting the setup flag on a good end of packet, and the external clear of that same flag. The bench raises `flag_clr` in the exact cycle that carries the good `eop_valid`. It then reads `setup_flag` one cycle later and expects it to be 1. The bench also places a fresh token in the middle of a pending transaction. A scoreboard queue then confirms that every byte write goes to the buffer of the second endpoint, and that none goes to the first.

// File: rtl/usbsetup_pkg.sv
// Package: shared PID codes and engine state type for the SETUP receiver.
// Assumes 4-bit PIDs with the check nibble already stripped upstream.
package usbsetup_pkg;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2,
        ST_DROP = 2'd3
    } rx_state_t;
endpackage

// File: rtl/usbsetup_desc_tbl.sv
// Descriptor table: one buffer base and one received-byte count per endpoint.
// The base is loaded from outside. The count is written by the engine on a good
// end of packet. Reads are combinational.
module usbsetup_desc_tbl #(
    parameter int NEP = 4,
    parameter int AW  = 12,
    parameter int CW  = 7,
    localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           base_we,
    input  logic [EPW-1:0] base_wep,
    input  logic [AW-1:0]  base_wval,
    input  logic           cnt_we,
    input  logic [EPW-1:0] cnt_wep,
    input  logic [CW-1:0]  cnt_wval,
    input  logic [EPW-1:0] fetch_ep,
    output logic [AW-1:0]  fetch_base,
    input  logic [EPW-1:0] rd_ep,
    output logic [AW-1:0]  rd_base,
    output logic [CW-1:0]  rd_cnt
);
    logic [AW-1:0] base_q [NEP];
    logic [CW-1:0] cnt_q  [NEP];

    for (genvar e = 0; e < NEP; e++) begin : g_ent
        // Hold this endpoint's base and count entries.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[e] <= '0;
                cnt_q[e]  <= '0;
            end else begin
                if (base_we && base_wep == EPW'(e)) base_q[e] <= base_wval;
                if (cnt_we && cnt_wep == EPW'(e))   cnt_q[e]  <= cnt_wval;
            end
        end

        p_cnt_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_we && cnt_wep == EPW'(e)) |=> (cnt_q[e] == $past(cnt_wval)));
    end

    // Drive the combinational read ports.
    always_comb begin
        fetch_base = base_q[fetch_ep];
        rd_base    = base_q[rd_ep];
        rd_cnt     = cnt_q[rd_ep];
    end
endmodule

// File: rtl/usbsetup_flags.sv
// Setup-received flags, one per endpoint. A set from the engine wins over a
// clear in the same cycle, so a just-completed SETUP is never lost.
module usbsetup_flags #(
    parameter int NEP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEP-1:0] set_i,
    input  logic [NEP-1:0] clr_i,
    output logic [NEP-1:0] flag_o
);
    logic [NEP-1:0] flag_q;

    for (genvar e = 0; e < NEP; e++) begin : g_flag
        // Update this endpoint's flag; a set takes priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q[e] <= 1'b0;
            else if (set_i[e]) flag_q[e] <= 1'b1;
            else if (clr_i[e]) flag_q[e] <= 1'b0;
        end

        p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[e] |=> flag_q[e]);
        p_clear_works_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[e] && !set_i[e]) |=> !flag_q[e]);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/usbsetup_fsm.sv
// Transaction engine. It qualifies the token, waits for DATA0, streams the
// payload bytes to memory up to the endpoint maximum, and on a good end of
// packet sets the flag and records the count. Any new token restarts the checks.
// Assumes the token, data PID, byte and end-of-packet strobes are one-cycle pulses.
module usbsetup_fsm
    import usbsetup_pkg::*;
#(
    parameter int NEP = 4,
    parameter int AW  = 12,
    parameter int CW  = 7,
    localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [6:0]      dev_addr_i,
    input  logic [NEP-1:0]  ep_en_i,
    input  logic [NEP-1:0]  ep_ctrl_i,
    input  logic [NEP*CW-1:0] ep_max_i,
    input  logic            tok_valid_i,
    input  logic [3:0]      tok_pid_i,
    input  logic [6:0]      tok_addr_i,
    input  logic [EPW-1:0]  tok_ep_i,
    input  logic            dpid_valid_i,
    input  logic [3:0]      dpid_i,
    input  logic            dpid_err_i,
    input  logic            byte_valid_i,
    input  logic [7:0]      byte_i,
    input  logic            eop_valid_i,
    input  logic            eop_good_i,
    input  logic [NEP-1:0]  flags_i,
    output logic [EPW-1:0]  fetch_ep_o,
    input  logic [AW-1:0]   fetch_base_i,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [7:0]      mem_wdata_o,
    output logic [NEP-1:0]  flag_set_o,
    output logic            cnt_we_o,
    output logic [EPW-1:0]  cnt_ep_o,
    output logic [CW-1:0]   cnt_val_o
);
    rx_state_t      state_q;
    logic [EPW-1:0] ep_q;
    logic [AW-1:0]  base_q;
    logic [CW-1:0]  max_q;
    logic [CW-1:0]  cnt_q;
    logic           tok_ok;
    logic           room;
    logic           eop_ok;

    // Token qualification chain: PID, address, enable, control type.
    always_comb begin
        tok_ok = (tok_pid_i == PID_SETUP) && (tok_addr_i == dev_addr_i)
              && ep_en_i[tok_ep_i] && ep_ctrl_i[tok_ep_i];
    end

    assign fetch_ep_o = tok_ep_i;
    assign room       = (cnt_q < max_q);
    assign eop_ok     = !tok_valid_i && (state_q == ST_RECV) && eop_valid_i && eop_good_i;

    // Byte write port, active while receiving with room left.
    always_comb begin
        mem_we_o    = !tok_valid_i && (state_q == ST_RECV) && byte_valid_i && room;
        mem_addr_o  = base_q + AW'(cnt_q);
        mem_wdata_o = byte_i;
    end

    // Completion outputs toward the flag bank and the descriptor table.
    always_comb begin
        flag_set_o = '0;
        if (eop_ok) flag_set_o[ep_q] = 1'b1;
        cnt_we_o  = eop_ok;
        cnt_ep_o  = ep_q;
        cnt_val_o = cnt_q;
    end

    // State register and per-transaction context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ep_q    <= '0;
            base_q  <= '0;
            max_q   <= '0;
            cnt_q   <= '0;
        end else if (tok_valid_i) begin
            state_q <= tok_ok ? ST_WAIT : ST_IDLE;
            if (tok_ok) begin
                ep_q   <= tok_ep_i;
                base_q <= fetch_base_i;
                max_q  <= ep_max_i[tok_ep_i*CW +: CW];
            end
        end else begin
            unique case (state_q)
                ST_WAIT: if (dpid_valid_i) begin
                    cnt_q <= '0;
                    if (dpid_err_i || dpid_i != PID_DATA0) state_q <= ST_IDLE;
                    else if (flags_i[ep_q])                state_q <= ST_DROP;
                    else                                   state_q <= ST_RECV;
                end
                ST_RECV: begin
                    if (eop_valid_i)              state_q <= ST_IDLE;
                    else if (byte_valid_i && room) cnt_q  <= cnt_q + 1'b1;
                end
                ST_DROP: if (eop_valid_i) state_q <= ST_IDLE;
                default: ;
            endcase
        end
    end

    p_addr_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && tok_addr_i != dev_addr_i) |=> (state_q == ST_IDLE));
    p_bad_dpid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tok_valid_i && state_q == ST_WAIT && dpid_valid_i && (dpid_err_i || dpid_i != PID_DATA0))
        |=> (state_q == ST_IDLE));
    p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV) |-> (cnt_q <= max_q));
    p_no_write_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !flags_i[ep_q]);
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid_i && state_q != ST_IDLE) |=> (state_q inside {ST_IDLE, ST_WAIT}));
endmodule

// File: rtl/usbsetup_rx.sv
// Top of the SETUP stage receiver: connects the descriptor table, the flag bank
// and the transaction engine. Assumes configuration inputs are stable while a
// transaction is in progress.
module usbsetup_rx #(
    parameter int NEP = 4,
    parameter int AW  = 12,
    parameter int CW  = 7,
    localparam int EPW = (NEP > 1) ? $clog2(NEP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        dev_addr,
    input  logic [NEP-1:0]    ep_enabled,
    input  logic [NEP-1:0]    ep_ctrl,
    input  logic [NEP*CW-1:0] ep_max_flat,
    input  logic              tok_valid,
    input  logic [3:0]        tok_pid,
    input  logic [6:0]        tok_addr,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              dpid_valid,
    input  logic [3:0]        dpid,
    input  logic              dpid_err,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              eop_valid,
    input  logic              eop_good,
    input  logic              desc_wr_en,
    input  logic [EPW-1:0]    desc_wr_ep,
    input  logic [AW-1:0]     desc_wr_addr,
    input  logic [EPW-1:0]    desc_rd_ep,
    output logic [AW-1:0]     desc_rd_addr,
    output logic [CW-1:0]     desc_rd_cnt,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [NEP-1:0]    flag_clr,
    output logic [NEP-1:0]    setup_flag
);
    logic [EPW-1:0] fetch_ep;
    logic [AW-1:0]  fetch_base;
    logic [NEP-1:0] flag_set;
    logic           cnt_we;
    logic [EPW-1:0] cnt_ep;
    logic [CW-1:0]  cnt_val;

    usbsetup_desc_tbl #(.NEP(NEP), .AW(AW), .CW(CW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .base_we(desc_wr_en), .base_wep(desc_wr_ep), .base_wval(desc_wr_addr),
        .cnt_we(cnt_we), .cnt_wep(cnt_ep), .cnt_wval(cnt_val),
        .fetch_ep(fetch_ep), .fetch_base(fetch_base),
        .rd_ep(desc_rd_ep), .rd_base(desc_rd_addr), .rd_cnt(desc_rd_cnt)
    );

    usbsetup_flags #(.NEP(NEP)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_i(flag_set), .clr_i(flag_clr), .flag_o(setup_flag)
    );

    usbsetup_fsm #(.NEP(NEP), .AW(AW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .dev_addr_i(dev_addr), .ep_en_i(ep_enabled), .ep_ctrl_i(ep_ctrl),
        .ep_max_i(ep_max_flat),
        .tok_valid_i(tok_valid), .tok_pid_i(tok_pid), .tok_addr_i(tok_addr), .tok_ep_i(tok_ep),
        .dpid_valid_i(dpid_valid), .dpid_i(dpid), .dpid_err_i(dpid_err),
        .byte_valid_i(byte_valid), .byte_i(byte_data),
        .eop_valid_i(eop_valid), .eop_good_i(eop_good),
        .flags_i(setup_flag),
        .fetch_ep_o(fetch_ep), .fetch_base_i(fetch_base),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .flag_set_o(flag_set),
        .cnt_we_o(cnt_we), .cnt_ep_o(cnt_ep), .cnt_val_o(cnt_val)
    );

    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (setup_flag == '0 && !mem_we));
endmodule

// File: tb/usbsetup_rx_tb.sv
// Scoreboard bench: drivers queue the expected buffer writes; a monitor at the
// falling edge pops and compares every write the design makes.
module usbsetup_rx_tb;
    localparam int NEP = 4, AW = 12, CW = 7, EPW = 2;
    localparam logic [3:0] SETUP = 4'b1101, OUTP = 4'b0001, D0 = 4'b0011, D1 = 4'b1011;
    localparam logic [6:0] MYADDR = 7'h2A;

    logic clk = 0, rst_n = 0;
    logic [6:0] dev_addr = MYADDR;
    logic [NEP-1:0] ep_enabled = 4'b0111, ep_ctrl = 4'b0101;
    logic [NEP*CW-1:0] ep_max_flat = {7'd8, 7'd4, 7'd8, 7'd8};
    logic tok_valid = 0; logic [3:0] tok_pid = 0; logic [6:0] tok_addr = 0; logic [EPW-1:0] tok_ep = 0;
    logic dpid_valid = 0; logic [3:0] dpid = 0; logic dpid_err = 0;
    logic byte_valid = 0; logic [7:0] byte_data = 0;
    logic eop_valid = 0, eop_good = 0;
    logic desc_wr_en = 0; logic [EPW-1:0] desc_wr_ep = 0; logic [AW-1:0] desc_wr_addr = 0;
    logic [EPW-1:0] desc_rd_ep = 0;
    logic [AW-1:0] desc_rd_addr; logic [CW-1:0] desc_rd_cnt;
    logic mem_we; logic [AW-1:0] mem_addr; logic [7:0] mem_wdata;
    logic [NEP-1:0] flag_clr = 0, setup_flag;

    int compared = 0, mismatched = 0;
    logic [AW+7:0] expq[$];

    usbsetup_rx #(.NEP(NEP), .AW(AW), .CW(CW)) u_dut (.*);

    always #2.5 clk = ~clk;

    task automatic check(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every design write must match the head of the queue.
    always @(negedge clk) if (rst_n && mem_we) begin
        compared++;
        if (expq.size() == 0) begin
            mismatched++;
            $display("FAIL R6 unexpected write actual=%0h:%0h expected=none", mem_addr, mem_wdata);
        end else begin
            logic [AW+7:0] e;
            e = expq.pop_front();
            if ({mem_addr, mem_wdata} != e) begin
                mismatched++;
                $display("FAIL R6 write actual=%0h expected=%0h", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic cyc(); @(posedge clk); #1; endtask

    task automatic token(logic [3:0] p, logic [6:0] a, logic [EPW-1:0] e);
        tok_valid = 1; tok_pid = p; tok_addr = a; tok_ep = e; cyc(); tok_valid = 0;
    endtask

    task automatic dphase(logic [3:0] p, logic err);
        dpid_valid = 1; dpid = p; dpid_err = err; cyc(); dpid_valid = 0; dpid_err = 0;
    endtask

    // Send n bytes; queue those expected to be written (the first lim of them).
    task automatic bytes(int n, int lim, logic [AW-1:0] base, logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            byte_valid = 1; byte_data = seed + 8'(i);
            if (i < lim) expq.push_back({base + AW'(i), byte_data});
            cyc();
        end
        byte_valid = 0;
    endtask

    task automatic eop(logic good, logic [NEP-1:0] clr);
        eop_valid = 1; eop_good = good; flag_clr = clr; cyc();
        eop_valid = 0; eop_good = 0; flag_clr = 0;
    endtask

    task automatic rdcnt(logic [EPW-1:0] e, string req, int exp);
        desc_rd_ep = e; #0.1; check(req, desc_rd_cnt, exp);
    endtask

    task automatic clr(logic [NEP-1:0] m); flag_clr = m; cyc(); flag_clr = 0; endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        // R12: reset state
        check("R12 flags", setup_flag, 0);
        check("R12 mem_we", mem_we, 0);
        check("R12 base", desc_rd_addr, 0);
        for (int e = 0; e < NEP; e++) rdcnt(EPW'(e), "R12 cnt", 0);
        rst_n = 1; cyc();
        for (int e = 0; e < NEP; e++) begin
            desc_wr_en = 1; desc_wr_ep = EPW'(e); desc_wr_addr = AW'(12'h100 * (e + 1)); cyc();
        end
        desc_wr_en = 0;

        // R6, R9: good SETUP on ep0, 8 bytes
        token(SETUP, MYADDR, 0); dphase(D0, 0); bytes(8, 8, 12'h100, 8'h10); eop(1, 0);
        check("R9 flag ep0", setup_flag, 4'b0001);
        rdcnt(0, "R9 cnt ep0", 8);

        // R8: flag set -> payload dropped
        token(SETUP, MYADDR, 0); dphase(D0, 0); bytes(3, 0, 12'h100, 8'h50); eop(1, 0);
        rdcnt(0, "R8 cnt unchanged", 8);
        check("R8 flag stays", setup_flag, 4'b0001);
        // R11: clear
        clr(4'b0001);
        check("R11 cleared", setup_flag, 0);

        // R1: address mismatch
        token(SETUP, 7'h2B, 0); dphase(D0, 0); bytes(2, 0, 0, 8'h60); eop(1, 0);
        check("R1 no flag", setup_flag, 0);
        // R2: disabled ep3
        token(SETUP, MYADDR, 3); dphase(D0, 0); bytes(2, 0, 0, 8'h70); eop(1, 0);
        check("R2 no flag", setup_flag, 0);
        rdcnt(3, "R2 cnt", 0);
        // R3: non-control ep1
        token(SETUP, MYADDR, 1); dphase(D0, 0); bytes(2, 0, 0, 8'h80); eop(1, 0);
        check("R3 no flag", setup_flag, 0);
        // R4: OUT token
        token(OUTP, MYADDR, 0); dphase(D0, 0); bytes(2, 0, 0, 8'h90); eop(1, 0);
        check("R4 no flag", setup_flag, 0);
        // R5: DATA1 and PID error
        token(SETUP, MYADDR, 0); dphase(D1, 0); bytes(2, 0, 0, 8'hA0); eop(1, 0);
        check("R5 data1 no flag", setup_flag, 0);
        token(SETUP, MYADDR, 0); dphase(D0, 1); bytes(2, 0, 0, 8'hB0); eop(1, 0);
        check("R5 pid err no flag", setup_flag, 0);

        // R7: ep2 max 4, send 6
        token(SETUP, MYADDR, 2); dphase(D0, 0); bytes(6, 4, 12'h300, 8'hC0); eop(1, 0);
        check("R7 flag ep2", setup_flag, 4'b0100);
        rdcnt(2, "R7 cnt capped", 4);
        clr(4'b0100);

        // R9: bad eop on ep0
        token(SETUP, MYADDR, 0); dphase(D0, 0); bytes(3, 3, 12'h100, 8'hD0); eop(0, 0);
        check("R9 bad eop no flag", setup_flag, 0);
        rdcnt(0, "R9 bad eop cnt kept", 8);

        // R10: token while waiting aborts; second token wins
        token(SETUP, MYADDR, 2); token(SETUP, MYADDR, 0);
        dphase(D0, 0); bytes(2, 2, 12'h100, 8'hE0); eop(1, 0);
        check("R10 flag ep0 only", setup_flag, 4'b0001);
        rdcnt(0, "R10 cnt ep0", 2);
        rdcnt(2, "R10 cnt ep2 kept", 4);
        clr(4'b0001);
        // R10: token while receiving aborts to a rejected endpoint
        token(SETUP, MYADDR, 0); dphase(D0, 0); bytes(1, 1, 12'h100, 8'h20);
        token(SETUP, MYADDR, 1); bytes(2, 0, 0, 8'h30); eop(1, 0);
        check("R10 abort no flag", setup_flag, 0);

        // R11: set and clear same cycle -> set wins
        token(SETUP, MYADDR, 0); dphase(D0, 0); bytes(1, 1, 12'h100, 8'h40); eop(1, 4'b0001);
        check("R11 set wins", setup_flag, 4'b0001);

        cyc();
        check("R6 queue drained", expq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule